// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic datapath of an accumulator-style processor, together with the four-bit status register it maintains. Each cycle it takes an accumulator byte and a second byte. A three-bit select chooses one of the eight-bit operations. A set of single-purpose strobes can take the place of that operation: increment, decrement, invert the accumulator, force carry, toggle carry, compare, a sixteen-bit pair add, and restoring the flags from a byte. The byte result and the sixteen-bit sum are combinational and are valid in the same cycle as the inputs. The flag register takes its new value only on a clock edge where `valid_in` is high.

The flags come out as a byte. The low nibble of that byte always reads zero. Decoding instructions, storing registers and driving memory are left to the surrounding core. The core picks an action, presents the operands and raises `valid_in` when the flag update should commit.

The flag register is the only state in the block and needs no controller. Its transitions are simple: reset loads the value 0xB0, a valid edge loads the computed next flags, and an idle edge holds the current flags.

Top module: `alu_flag_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, the flag byte reads 0xB0: zero=1, subtract=0, half-carry=1, carry=1.
- R2: The flags change only on a rising clock edge where `valid_in` is 1. The new flags are visible one edge after the stimulus. `result_out` and `wide_sum_out` are combinational and valid in the same cycle.
- R3: When no strobe is raised, `op_sel` selects the operation. Code 0 gives A+B. Code 1 gives A+B+carry. Code 2 gives A-B. Code 3 gives A-B-carry. For these four codes, carry becomes the carry out of bit 7 for additions and the borrow for subtractions.
- R4: Code 4 gives A AND B, code 5 gives A XOR B, and codes 6 and 7 give A OR B. All of them clear carry. AND sets half-carry, and the other logic codes clear it.
- R5: For every `op_sel` operation, zero is set exactly when the 8-bit result is 0. Subtract is set for codes 2 and 3 and cleared for all other codes.
- R6: Half-carry is the carry out of bit 3 for additions and the borrow into bit 3 for subtractions. The carry or borrow input is included in that nibble computation.
- R7: Increment gives A+1 and decrement gives A-1. Each one sets zero from its result and half-carry from the nibble, and leaves carry unchanged. Increment clears subtract and decrement sets it.
- R8: Invert gives NOT A, sets subtract and half-carry, and leaves zero and carry unchanged. Set-carry forces carry=1 and clears subtract and half-carry. Toggle-carry inverts carry and clears subtract. Both carry strobes leave the remaining flags unchanged and output A as the result.
- R9: Compare evaluates A-B. It sets zero, half-carry and carry from that difference and sets subtract. The difference is discarded: `result_out` equals A.
- R10: The wide add drives `wide_sum_out` = PA+PB modulo 2^16 at all times. Under its strobe, carry becomes the carry out of bit 15, subtract clears, and zero and half-carry hold.
- R11: The flag byte is laid out as zero at bit 7, subtract at bit 6, half-carry at bit 5, carry at bit 4, and bits 3..0 always read 0. The flag load strobe copies B[7:4] into the flags and ignores B[3:0].
- R12: When more than one strobe is high, the highest priority wins, in this order: load, compare, increment, decrement, invert, set-carry, toggle-carry, wide add, then `op_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Commit the computed flags on this edge |
| acc_in | input | 8 | Accumulator operand A |
| opnd_in | input | 8 | Second operand B, and the source for a flag load |
| op_sel | input | 3 | Operation code used when no strobe is active |
| do_load | input | 1 | Load flags from B[7:4] |
| do_cmp | input | 1 | Compare A with B |
| do_inc | input | 1 | Increment A |
| do_dec | input | 1 | Decrement A |
| do_inv | input | 1 | Invert A |
| do_setc | input | 1 | Force carry to 1 |
| do_flipc | input | 1 | Toggle carry |
| do_wide | input | 1 | Use the 16-bit pair add for the carry |
| pair_a_in | input | 16 | Wide operand PA |
| pair_b_in | input | 16 | Wide operand PB |
| result_out | output | 8 | Byte result |
| wide_sum_out | output | 16 | PA+PB modulo 2^16 |
| flags_out | output | 8 | Packed flag byte |

## Verification
`result_out` and `wide_sum_out` are due in the same cycle the inputs are applied. The bench drives a stimulus just after a falling edge and compares these two outputs one time unit later, before the next rising edge. The flag byte is due one rising edge after a `valid_in` stimulus. The reference model commits its own flags at that edge, and `flags_out` is compared at the following falling edge. When `valid_in` is low, the same comparison confirms that the flags held.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBC = 3'd3,
        OP_AND = 3'd4,
        OP_XOR = 3'd5,
        OP_OR  = 3'd6,
        OP_OR7 = 3'd7
    } alu_op_e;

    typedef enum logic [3:0] {
        ACT_ALU,
        ACT_WIDE,
        ACT_FLIPC,
        ACT_SETC,
        ACT_INV,
        ACT_DEC,
        ACT_INC,
        ACT_CMP,
        ACT_LOAD
    } alu_act_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{z: 1'b1, n: 1'b0, h: 1'b1, c: 1'b1};

endpackage

// File: rtl/alu_act_select.sv
module alu_act_select
    import alu_flag_pkg::*;
(
    input  logic     load_i,
    input  logic     cmp_i,
    input  logic     inc_i,
    input  logic     dec_i,
    input  logic     inv_i,
    input  logic     setc_i,
    input  logic     flipc_i,
    input  logic     wide_i,
    output alu_act_e act_o
);
    always_comb begin
        if (load_i)       act_o = ACT_LOAD;
        else if (cmp_i)   act_o = ACT_CMP;
        else if (inc_i)   act_o = ACT_INC;
        else if (dec_i)   act_o = ACT_DEC;
        else if (inv_i)   act_o = ACT_INV;
        else if (setc_i)  act_o = ACT_SETC;
        else if (flipc_i) act_o = ACT_FLIPC;
        else if (wide_i)  act_o = ACT_WIDE;
        else              act_o = ACT_ALU;
    end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import alu_flag_pkg::*;
#(
    parameter int DW = 8,
    parameter int HB = 4
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  alu_op_e       op_i,
    input  logic          cin_i,
    output logic [DW-1:0] res_o,
    output logic          cy_o,
    output logic          hc_o
);
    logic [DW:0] wide_r;
    logic [HB:0] nib_r;

    always_comb begin
        wide_r = '0;
        nib_r  = '0;
        res_o  = '0;
        cy_o   = 1'b0;
        hc_o   = 1'b0;
        unique case (op_i)
            OP_ADD, OP_ADC: begin
                wide_r = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
                nib_r  = {1'b0, a_i[HB-1:0]} + {1'b0, b_i[HB-1:0]} + {{HB{1'b0}}, cin_i};
                res_o  = wide_r[DW-1:0];
                cy_o   = wide_r[DW];
                hc_o   = nib_r[HB];
            end
            OP_SUB, OP_SBC: begin
                wide_r = {1'b0, a_i} - {1'b0, b_i} - {{DW{1'b0}}, cin_i};
                nib_r  = {1'b0, a_i[HB-1:0]} - {1'b0, b_i[HB-1:0]} - {{HB{1'b0}}, cin_i};
                res_o  = wide_r[DW-1:0];
                cy_o   = wide_r[DW];
                hc_o   = nib_r[HB];
            end
            OP_AND: begin
                res_o = a_i & b_i;
                hc_o  = 1'b1;
            end
            OP_XOR: res_o = a_i ^ b_i;
            OP_OR, OP_OR7: res_o = a_i | b_i;
        endcase
    end
endmodule

// File: rtl/wide_adder.sv
module wide_adder #(
    parameter int WW = 16
) (
    input  logic [WW-1:0] a_i,
    input  logic [WW-1:0] b_i,
    output logic [WW-1:0] sum_o,
    output logic          cy_o
);
    logic [WW:0] full_r;
    assign full_r = {1'b0, a_i} + {1'b0, b_i};
    assign sum_o  = full_r[WW-1:0];
    assign cy_o   = full_r[WW];
endmodule

// File: rtl/flag_reg.sv
module flag_reg
    import alu_flag_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   we_i,
    input  flags_t d_i,
    output flags_t q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q_o <= FLAGS_RESET;
        else if (we_i) q_o <= d_i;
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int DW = 8,
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_in,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] opnd_in,
    input  logic [2:0]    op_sel,
    input  logic          do_load,
    input  logic          do_cmp,
    input  logic          do_inc,
    input  logic          do_dec,
    input  logic          do_inv,
    input  logic          do_setc,
    input  logic          do_flipc,
    input  logic          do_wide,
    input  logic [WW-1:0] pair_a_in,
    input  logic [WW-1:0] pair_b_in,
    output logic [DW-1:0] result_out,
    output logic [WW-1:0] wide_sum_out,
    output logic [7:0]    flags_out
);
    localparam int HB = DW / 2;

    alu_act_e      act;
    alu_op_e       core_op;
    logic [DW-1:0] core_b;
    logic          core_cin;
    logic [DW-1:0] core_res;
    logic          core_cy;
    logic          core_hc;
    logic          wide_cy;
    flags_t        flags_q;
    flags_t        flags_d;

    alu_act_select u_sel (
        .load_i (do_load),
        .cmp_i  (do_cmp),
        .inc_i  (do_inc),
        .dec_i  (do_dec),
        .inv_i  (do_inv),
        .setc_i (do_setc),
        .flipc_i(do_flipc),
        .wide_i (do_wide),
        .act_o  (act)
    );

    always_comb begin
        core_op  = alu_op_e'(op_sel);
        core_b   = opnd_in;
        core_cin = 1'b0;
        unique case (act)
            ACT_INC: begin core_op = OP_ADD; core_b = DW'(1); end
            ACT_DEC: begin core_op = OP_SUB; core_b = DW'(1); end
            ACT_CMP: core_op = OP_SUB;
            default: core_cin = (core_op == OP_ADC || core_op == OP_SBC) ? flags_q.c : 1'b0;
        endcase
    end

    byte_alu #(.DW(DW), .HB(HB)) u_core (
        .a_i  (acc_in),
        .b_i  (core_b),
        .op_i (core_op),
        .cin_i(core_cin),
        .res_o(core_res),
        .cy_o (core_cy),
        .hc_o (core_hc)
    );

    wide_adder #(.WW(WW)) u_wide (
        .a_i  (pair_a_in),
        .b_i  (pair_b_in),
        .sum_o(wide_sum_out),
        .cy_o (wide_cy)
    );

    always_comb begin
        flags_d    = flags_q;
        result_out = acc_in;
        unique case (act)
            ACT_ALU: begin
                result_out = core_res;
                flags_d.z  = (core_res == '0);
                flags_d.n  = (core_op == OP_SUB || core_op == OP_SBC);
                flags_d.h  = core_hc;
                flags_d.c  = op_sel[2] ? 1'b0 : core_cy;
            end
            ACT_INC, ACT_DEC: begin
                result_out = core_res;
                flags_d.z  = (core_res == '0);
                flags_d.n  = (act == ACT_DEC);
                flags_d.h  = core_hc;
            end
            ACT_CMP: begin
                flags_d.z = (core_res == '0);
                flags_d.n = 1'b1;
                flags_d.h = core_hc;
                flags_d.c = core_cy;
            end
            ACT_INV: begin
                result_out = ~acc_in;
                flags_d.n  = 1'b1;
                flags_d.h  = 1'b1;
            end
            ACT_SETC: begin
                flags_d.c = 1'b1;
                flags_d.n = 1'b0;
                flags_d.h = 1'b0;
            end
            ACT_FLIPC: begin
                flags_d.c = ~flags_q.c;
                flags_d.n = 1'b0;
            end
            ACT_WIDE: begin
                flags_d.c = wide_cy;
                flags_d.n = 1'b0;
            end
            ACT_LOAD: flags_d = flags_t'(opnd_in[DW-1:DW-4]);
        endcase
    end

    flag_reg u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .we_i (valid_in),
        .d_i  (flags_d),
        .q_o  (flags_q)
    );

    assign flags_out = {flags_q, 4'b0000};

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(flags_out));

    // R5
    sub_sets_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in && act == ACT_ALU && op_sel[2:1] == 2'b01 |=> flags_out[6]);

    // R4
    logic_clears_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in && act == ACT_ALU && op_sel[2] |=> !flags_out[4]);

    // R8
    setc_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in && act == ACT_SETC |=> flags_out[6:4] == 3'b001);

    // R10
    wide_keeps_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in && act == ACT_WIDE |=> flags_out[7] == $past(flags_out[7]));

    // R9
    cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_CMP |-> result_out == acc_in);
endmodule

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [7:0]  acc_in = '0, opnd_in = '0;
    logic [2:0]  op_sel = '0;
    logic        do_load = 0, do_cmp = 0, do_inc = 0, do_dec = 0;
    logic        do_inv = 0, do_setc = 0, do_flipc = 0, do_wide = 0;
    logic [15:0] pair_a_in = '0, pair_b_in = '0;
    logic [7:0]  result_out;
    logic [15:0] wide_sum_out;
    logic [7:0]  flags_out;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    // model flags
    bit mz = 1, mn = 0, mh = 1, mc = 1;
    int e_res, e_wide;
    bit nz, nn, nh, nc;

    always #(CLK_P/2) clk = ~clk;

    alu_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
        .acc_in(acc_in), .opnd_in(opnd_in), .op_sel(op_sel),
        .do_load(do_load), .do_cmp(do_cmp), .do_inc(do_inc), .do_dec(do_dec),
        .do_inv(do_inv), .do_setc(do_setc), .do_flipc(do_flipc), .do_wide(do_wide),
        .pair_a_in(pair_a_in), .pair_b_in(pair_b_in),
        .result_out(result_out), .wide_sum_out(wide_sum_out), .flags_out(flags_out)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int pack_flags();
        return (int'(mz) << 7) | (int'(mn) << 6) | (int'(mh) << 5) | (int'(mc) << 4);
    endfunction

    // strobe bits: 0 load,1 cmp,2 inc,3 dec,4 inv,5 setc,6 flipc,7 wide
    task automatic model(input int a, input int b, input int sel, input logic [7:0] s,
                         input int pa, input int pb);
        int r, ci;
        nz = mz; nn = mn; nh = mh; nc = mc;
        e_res = a;
        e_wide = (pa + pb) & 16'hFFFF;
        if (s[0]) begin
            nz = b[7]; nn = b[6]; nh = b[5]; nc = b[4];
        end else if (s[1]) begin
            r = a - b; nz = ((r & 255) == 0); nn = 1; nh = (a & 15) < (b & 15); nc = a < b;
        end else if (s[2]) begin
            e_res = (a + 1) & 255; nz = (e_res == 0); nn = 0; nh = ((a & 15) == 15);
        end else if (s[3]) begin
            e_res = (a - 1) & 255; nz = (e_res == 0); nn = 1; nh = ((a & 15) == 0);
        end else if (s[4]) begin
            e_res = (~a) & 255; nn = 1; nh = 1;
        end else if (s[5]) begin
            nc = 1; nn = 0; nh = 0;
        end else if (s[6]) begin
            nc = !mc; nn = 0;
        end else if (s[7]) begin
            nc = (pa + pb) > 65535; nn = 0;
        end else begin
            ci = (sel == 1 || sel == 3) ? int'(mc) : 0;
            case (sel)
                0, 1: begin
                    r = a + b + ci; nh = ((a & 15) + (b & 15) + ci) > 15;
                    nc = r > 255; nn = 0;
                end
                2, 3: begin
                    r = a - b - ci; nh = ((a & 15) - (b & 15) - ci) < 0;
                    nc = r < 0; nn = 1;
                end
                4: begin r = a & b; nh = 1; nc = 0; nn = 0; end
                5: begin r = a ^ b; nh = 0; nc = 0; nn = 0; end
                default: begin r = a | b; nh = 0; nc = 0; nn = 0; end
            endcase
            e_res = r & 255;
            nz = (e_res == 0);
        end
    endtask

    task automatic step(string tag, input int a, input int b, input int sel,
                        input logic [7:0] s, input bit v, input int pa, input int pb);
        acc_in = 8'(a); opnd_in = 8'(b); op_sel = 3'(sel);
        {do_wide, do_flipc, do_setc, do_inv, do_dec, do_inc, do_cmp, do_load} = s;
        pair_a_in = 16'(pa); pair_b_in = 16'(pb); valid_in = v;
        #1;
        model(a, b, sel, s, pa, pb);
        check({tag, " result"}, int'(result_out), e_res);
        check({tag, " wide sum R10"}, int'(wide_sum_out), e_wide);
        @(posedge clk);
        if (v) begin mz = nz; mn = nn; mh = nh; mc = nc; end
        @(negedge clk);
        check({tag, " flags"}, int'(flags_out), pack_flags());
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R1 flags in reset", int'(flags_out), 8'hB0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flags after reset", int'(flags_out), 8'hB0);

        step("R2 idle add", 8'h01, 8'h01, 0, 8'h00, 0, 0, 0);
        step("R3 add carry", 8'hF0, 8'h20, 0, 8'h00, 1, 0, 0);
        step("R3 adc carry-in", 8'h10, 8'h05, 1, 8'h00, 1, 0, 0);
        step("R6 add nibble", 8'h0F, 8'h01, 0, 8'h00, 1, 0, 0);
        step("R5 add zero", 8'hFF, 8'h01, 0, 8'h00, 1, 0, 0);
        step("R3 sbc borrow-in", 8'h10, 8'h0F, 3, 8'h00, 1, 0, 0);
        step("R3 sub borrow", 8'h05, 8'h06, 2, 8'h00, 1, 0, 0);
        step("R6 sbc nibble", 8'h20, 8'h00, 3, 8'h00, 1, 0, 0);
        step("R4 and", 8'hF0, 8'h3C, 4, 8'h00, 1, 0, 0);
        step("R4 xor zero", 8'h5A, 8'h5A, 5, 8'h00, 1, 0, 0);
        step("R4 or code7", 8'h01, 8'h80, 7, 8'h00, 1, 0, 0);
        step("R8 setc", 8'h11, 8'h00, 0, 8'h20, 1, 0, 0);
        step("R7 inc wrap", 8'hFF, 8'h00, 0, 8'h04, 1, 0, 0);
        step("R7 dec nibble", 8'h10, 8'h00, 0, 8'h08, 1, 0, 0);
        step("R8 inv", 8'h3C, 8'h00, 0, 8'h10, 1, 0, 0);
        step("R8 flipc", 8'h3C, 8'h00, 0, 8'h40, 1, 0, 0);
        step("R9 cmp equal", 8'h42, 8'h42, 0, 8'h02, 1, 0, 0);
        step("R9 cmp less", 8'h41, 8'h42, 0, 8'h02, 1, 0, 0);
        step("R10 wide carry", 8'h00, 8'h00, 0, 8'h80, 1, 16'hFFFF, 16'h0002);
        step("R10 wide no carry", 8'h00, 8'h00, 0, 8'h80, 1, 16'h1234, 16'h0001);
        step("R11 load low nibble ignored", 8'h00, 8'h5F, 0, 8'h01, 1, 0, 0);
        step("R11 load all", 8'h00, 8'hFF, 0, 8'h01, 1, 0, 0);
        step("R12 cmp beats inc", 8'h07, 8'h09, 0, 8'h06, 1, 0, 0);
        step("R12 load beats all", 8'h07, 8'h90, 0, 8'hFF, 1, 0, 0);
        step("R12 dec beats setc", 8'h01, 8'h00, 0, 8'h28, 1, 0, 0);
        step("R2 idle setc", 8'h00, 8'h00, 0, 8'h20, 0, 0, 0);

        for (int i = 0; i < 600; i++) begin
            logic [7:0] s;
            int pick;
            pick = $urandom_range(0, 15);
            s = (pick < 8) ? 8'(1 << pick) : 8'h00;
            if (pick == 15) s = 8'($urandom_range(0, 255));
            step("R12 random", $urandom_range(0, 255), $urandom_range(0, 255),
                 $urandom_range(0, 7), s, ($urandom_range(0, 4) != 0),
                 $urandom_range(0, 65535), $urandom_range(0, 65535));
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule